// File: doc/BRIEF.md
# Multiprocessor Interrupt Router with Priority-Level Mapping

This block collects 32 level-sensitive device interrupt lines into a pending register, masks them with a disable register that software controls, and folds the surviving lines into a 15-level priority vector. The vector goes to one processor, chosen by a target register. Several lines may share one priority level, and some lines map to no level at all. Every other processor sees a zero vector. Bit 31 of the disable register is a master switch. While it is set, no processor receives any hard level.

Software reaches the block through a small word-addressed port. Each access moves one 32-bit word, and the port has one write strobe. Reads are combinational on the word index. The disable register has separate words for setting and for clearing bits, so software can change some bits without a read-modify-write. Besides the gated vector, the block drives an unmasked vector to the target processor for status readback. It also drives a broadcast flag that follows any level-15 source.

Per-processor state lives in `rt_cpu` tiles built by a generate loop. Each tile compares its own index with the 4-bit target value. No tile has a state machine: the routing is pure combinational logic over three registers.

Top module: `irq_level_router`

## Requirements
- R1: On every rising clock edge each pending bit takes the level of its input line. Lines whose mapped level is 0 (bits 23, 24, 25, 26 and 31) never become pending.
- R2: Input bits 0 to 31 map, in that order, to levels 2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0. A level vector has bit L set for each qualifying input whose level is L, and bit 0 is always 0.
- R3: Reading word 0 returns the pending register with bit 31 forced to 0.
- R4: Reading word 1 returns the disable register ANDed with the valid mask 0xF05DFF80.
- R5: Writing word 2 clears the disable bits where (wdata AND 0xF05DFF80) is 1. Writing word 3 sets them the same way. Neither write alters pending bits.
- R6: Writing word 4 stores wdata[3:0] as the target, and reading word 4 returns it zero-extended. Words 5 to 7 read as 0, and writes to them change nothing.
- R7: `master_dis` equals disable bit 31. While it is 1, every processor's hard vector is 0.
- R8: The target processor's hard vector is the R2 map of (pending AND NOT disable). Every other processor receives 0, and a target value of NCPU or more selects no processor.
- R9: After reset, pending is 0, the target is 0 and the disable register holds 0x0FA2007F, so `master_dis` is 0 and word 1 reads 0.
- R10: `bcast15` is 1 exactly when any pending bit among 27 to 30 (the level-15 sources) is 1, regardless of the disable register.
- R11: The target processor's raw vector is the R2 map of pending without any masking, not even the master disable. Other processors receive 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Device interrupt levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word index for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the word at addr (combinational) |
| hard_lvl | output | NCPU*16 | Gated level vector per processor, processor c in bits [16c+15:16c] |
| raw_lvl | output | NCPU*16 | Unmasked level vector per processor, same layout |
| master_dis | output | 1 | Master disable flag |
| bcast15 | output | 1 | Level-15 broadcast to all processors |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any check counts. They also assume that `wr_en`, `addr` and `wdata` are stable around each rising edge, because a write is taken from their values at the edge. The bench changes all inputs only on falling edges. It draws target values over the full 4-bit range, so out-of-range targets occur, and it writes every word index, including the unused ones. Seeded random `irq_in` patterns and random disable writes are mixed with a per-bit sweep of the level map and with directed toggling of the master disable.

// File: rtl/rt_pkg.sv
package rt_pkg;
    localparam int unsigned SRC_N  = 32;
    localparam int unsigned LVL_N  = 16;
    localparam int unsigned TGT_W  = 4;
    localparam int unsigned WORD_W = 3;

    localparam logic [SRC_N-1:0] VALID_MASK = 32'hF05D_FF80;
    localparam logic [SRC_N-1:0] DIS_RESET  = ~VALID_MASK;
    localparam int unsigned      MASTER_BIT = 31;

    typedef enum logic [WORD_W-1:0] {
        W_PEND   = 3'd0,
        W_DIS    = 3'd1,
        W_ENABLE = 3'd2,
        W_DISSET = 3'd3,
        W_TARGET = 3'd4
    } word_e;

    function automatic logic [3:0] lvl_of(input int unsigned idx);
        logic [3:0] l;
        unique case (idx)
            0, 7:             l = 4'd2;
            1, 8:             l = 4'd3;
            2, 9:             l = 4'd5;
            3, 10:            l = 4'd7;
            4, 11, 21:        l = 4'd9;
            5, 12, 22:        l = 4'd11;
            6, 13, 17:        l = 4'd13;
            14, 15:           l = 4'd12;
            16:               l = 4'd6;
            18:               l = 4'd4;
            19:               l = 4'd10;
            20:               l = 4'd8;
            27, 28, 29, 30:   l = 4'd15;
            default:          l = 4'd0;
        endcase
        return l;
    endfunction

    function automatic logic [SRC_N-1:0] src_mask();
        logic [SRC_N-1:0] m;
        for (int unsigned i = 0; i < SRC_N; i++) begin
            m[i] = (lvl_of(i) != 4'd0);
        end
        return m;
    endfunction
endpackage

// File: rtl/rt_lvl_map.sv
module rt_lvl_map
    import rt_pkg::*;
(
    input  logic [SRC_N-1:0] bits,
    output logic [LVL_N-1:0] vec
);
    always_comb begin
        vec = '0;
        for (int unsigned i = 0; i < SRC_N; i++) begin
            if (bits[i] && (lvl_of(i) != 4'd0)) begin
                vec[lvl_of(i)] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rt_cfg_regs.sv
module rt_cfg_regs
    import rt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] addr,
    input  logic [SRC_N-1:0]  wdata,
    input  logic [SRC_N-1:0]  pend,
    output logic [SRC_N-1:0]  dis_q,
    output logic [TGT_W-1:0]  tgt_q,
    output logic [SRC_N-1:0]  rdata
);
    logic [SRC_N-1:0] wmask;
    assign wmask = wdata & VALID_MASK;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q <= DIS_RESET;
            tgt_q <= '0;
        end else if (wr_en) begin
            case (word_e'(addr))
                W_ENABLE: dis_q <= dis_q & ~wmask;
                W_DISSET: dis_q <= dis_q | wmask;
                W_TARGET: tgt_q <= wdata[TGT_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (word_e'(addr))
            W_PEND:   rdata = pend & ~(SRC_N'(1) << MASTER_BIT);
            W_DIS:    rdata = dis_q & VALID_MASK;
            W_TARGET: rdata = SRC_N'(tgt_q);
            default:  rdata = '0;
        endcase
    end

    // R5
    clr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == W_ENABLE) |=> ((dis_q & $past(wmask)) == '0));
    // R5
    set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == W_DISSET) |=> ((dis_q & $past(wmask)) == $past(wmask)));
    // R6
    tgt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == W_TARGET) |=> (tgt_q == $past(wdata[TGT_W-1:0])));
endmodule

// File: rtl/rt_cpu.sv
module rt_cpu
    import rt_pkg::*;
#(
    parameter int unsigned IDX = 0
) (
    input  logic [TGT_W-1:0] tgt,
    input  logic             master_off,
    input  logic [LVL_N-1:0] gated_vec,
    input  logic [LVL_N-1:0] raw_vec,
    output logic [LVL_N-1:0] hard_out,
    output logic [LVL_N-1:0] raw_out
);
    logic sel;
    assign sel      = (32'(tgt) == IDX);
    assign hard_out = (sel && !master_off) ? gated_vec : '0;
    assign raw_out  = sel ? raw_vec : '0;
endmodule

// File: rtl/irq_level_router.sv
module irq_level_router
    import rt_pkg::*;
#(
    parameter int unsigned NCPU = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        irq_in,
    input  logic               wr_en,
    input  logic [2:0]         addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic [NCPU*16-1:0] hard_lvl,
    output logic [NCPU*16-1:0] raw_lvl,
    output logic               master_dis,
    output logic               bcast15
);
    localparam logic [SRC_N-1:0] SRC_MASK = src_mask();

    logic [SRC_N-1:0] pend_q;
    logic [SRC_N-1:0] dis_q;
    logic [TGT_W-1:0] tgt_q;
    logic [LVL_N-1:0] gated_vec;
    logic [LVL_N-1:0] raw_vec;
    logic [NCPU-1:0]  cpu_act;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= irq_in & SRC_MASK;
        end
    end

    rt_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .pend  (pend_q),
        .dis_q (dis_q),
        .tgt_q (tgt_q),
        .rdata (rdata)
    );

    rt_lvl_map u_map_gated (
        .bits (pend_q & ~dis_q),
        .vec  (gated_vec)
    );

    rt_lvl_map u_map_raw (
        .bits (pend_q),
        .vec  (raw_vec)
    );

    assign master_dis = dis_q[MASTER_BIT];
    assign bcast15    = raw_vec[LVL_N-1];

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        rt_cpu #(.IDX(c)) u_cpu (
            .tgt        (tgt_q),
            .master_off (dis_q[MASTER_BIT]),
            .gated_vec  (gated_vec),
            .raw_vec    (raw_vec),
            .hard_out   (hard_lvl[c*LVL_N +: LVL_N]),
            .raw_out    (raw_lvl[c*LVL_N +: LVL_N])
        );
        assign cpu_act[c] = |hard_lvl[c*LVL_N +: LVL_N];

        // R11
        hard_in_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hard_lvl[c*LVL_N +: LVL_N] & ~raw_lvl[c*LVL_N +: LVL_N]) == '0);
        // R2
        lvl0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !hard_lvl[c*LVL_N] && !raw_lvl[c*LVL_N]);
    end

    // R7
    master_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        master_dis |-> (hard_lvl == '0));
    // R8
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cpu_act));
    // R1
    no_lvl0_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd0) |-> (rdata[26:23] == 4'b0));
endmodule

// File: tb/tb_irq_level_router.sv
`timescale 1ns/1ps
module tb_irq_level_router;
    localparam int NCPU = 4;
    localparam logic [31:0] VM  = 32'hF05D_FF80;
    localparam logic [31:0] SRC = 32'h787F_FFFF;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [31:0]        irq_in = '0;
    logic               wr_en = 1'b0;
    logic [2:0]         addr = '0;
    logic [31:0]        wdata = '0;
    logic [31:0]        rdata;
    logic [NCPU*16-1:0] hard_lvl;
    logic [NCPU*16-1:0] raw_lvl;
    logic               master_dis;
    logic               bcast15;

    int total = 0;
    int bad = 0;
    logic [31:0] mpend, mdis;
    logic [3:0]  mtgt;

    always #4 clk = ~clk;

    irq_level_router #(.NCPU(NCPU)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .hard_lvl(hard_lvl),
        .raw_lvl(raw_lvl), .master_dis(master_dis), .bcast15(bcast15)
    );

    function automatic int lvl(input int i);
        int t[32] = '{2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,
                      6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0};
        return t[i];
    endfunction

    function automatic logic [15:0] vec_of(input logic [31:0] b);
        logic [15:0] v = '0;
        for (int i = 0; i < 32; i++) begin
            if (b[i] && lvl(i) != 0) v[lvl(i)] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [31:0] exp_read(input int w);
        case (w)
            0: return mpend & 32'h7FFF_FFFF;
            1: return mdis & VM;
            4: return {28'b0, mtgt};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [31:0] irq, input logic we,
                        input logic [2:0] a, input logic [31:0] d);
        irq_in = irq; wr_en = we; addr = a; wdata = d;
        @(posedge clk);
        mpend = irq & SRC;
        if (we) begin
            case (a)
                3'd2: mdis = mdis & ~(d & VM);
                3'd3: mdis = mdis | (d & VM);
                3'd4: mtgt = d[3:0];
                default: ;
            endcase
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_all();
        for (int c = 0; c < NCPU; c++) begin
            logic [15:0] eh, er;
            eh = (c == int'(mtgt) && !mdis[31]) ? vec_of(mpend & ~mdis) : 16'h0;
            er = (c == int'(mtgt)) ? vec_of(mpend) : 16'h0;
            chk("R8 hard vector", 64'(hard_lvl[c*16 +: 16]), 64'(eh));
            chk("R11 raw vector", 64'(raw_lvl[c*16 +: 16]), 64'(er));
        end
        chk("R7 master flag", 64'(master_dis), 64'(mdis[31]));
        chk("R10 broadcast", 64'(bcast15), 64'(|mpend[30:27]));
        for (int w = 0; w < 8; w++) begin
            addr = 3'(w);
            #1;
            chk("R3 R4 R6 read word", 64'(rdata), 64'(exp_read(w)));
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd5150));
        mpend = '0; mdis = 32'h0FA2_007F; mtgt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        chk("R9 master after reset", 64'(master_dis), 64'd0);
        addr = 3'd1; #1;
        chk("R9 disable readback", 64'(rdata), 64'd0);
        addr = 3'd4; #1;
        chk("R9 target", 64'(rdata), 64'd0);
        check_all();

        // R1 R2 single-bit sweep of the map on raw vector of CPU 0
        for (int i = 0; i < 32; i++) begin
            step(32'h1 << i, 1'b0, 3'd0, 32'h0);
            chk("R2 map raw", 64'(raw_lvl[15:0]),
                64'(lvl(i) != 0 ? (16'h1 << lvl(i)) : 16'h0));
            addr = 3'd0; #1;
            chk("R1 pending follows line", 64'(rdata),
                64'((lvl(i) != 0) ? (32'h1 << i) : 32'h0));
        end

        // R5 enable all valid sources, pending unchanged by the write
        step(32'hFFFF_FFFF, 1'b0, 3'd0, 32'h0);
        step(32'hFFFF_FFFF, 1'b1, 3'd2, 32'h7FFF_FFFF);
        addr = 3'd0; #1;
        chk("R5 pending unaffected by enable write", 64'(rdata), 64'(SRC));
        check_all();

        // R7 master disable on then off
        step(32'hFFFF_FFFF, 1'b1, 3'd3, 32'h8000_0000);
        chk("R7 hard gated off", 64'(hard_lvl), 64'd0);
        chk("R10 broadcast ignores master", 64'(bcast15), 64'd1);
        check_all();
        step(32'hFFFF_FFFF, 1'b1, 3'd2, 32'h8000_0000);
        check_all();

        // R8 out-of-range target, R6 unused word write ignored
        step(32'h7800_0000, 1'b1, 3'd4, 32'hFFFF_FFF9);
        chk("R8 no cpu for target 9", 64'(hard_lvl | raw_lvl), 64'd0);
        step(32'h7800_0000, 1'b1, 3'd5, 32'hFFFF_FFFF);
        check_all();
        step(32'h0000_0000, 1'b1, 3'd4, 32'h0000_0002);
        check_all();

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r, d;
            logic [2:0]  a;
            r = $urandom;
            d = $urandom;
            a = 3'($urandom_range(0, 7));
            if (($urandom & 3) != 0) d[31] = 1'b0;
            step(r, ($urandom & 1) == 1, a, d);
            check_all();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule